// File: doc/BRIEF.md
# Stream Packet Combiner

This block sits on a receive stream and folds consecutive payload packets into longer output bursts, so a downstream DMA engine sees fewer and larger transfers. Each input packet is first stored whole in an internal buffer. A packet becomes visible to the output side only once its final beat has arrived without an error mark. A packet whose final beat carries the error flag is removed by moving the write pointer back to the last committed position, so it never reaches the output.

On the output side the boundary logic suppresses the last flag at the end of each packet while another complete packet is already waiting. The flag is raised at a packet end in two cases: nothing further is buffered at that moment, or the burst already holds the configured maximum number of packets. A merge counter restarts after every emitted last. The block runs on its own, with no trigger. Beat data and byte enables pass through unchanged.

Top module: `pkt_combiner`

## Requirements
- R1: The output carries the beats of the good input packets in arrival order, with data and byte-enable (keep) of each beat unchanged.
- R2: A packet whose final beat has s_user = 1 is dropped whole: none of its beats reaches the output, and later packets are unaffected.
- R3: m_last is 1 only on a beat that was the final beat of an input packet.
- R4: At a packet's final beat, m_last is 1 when no other complete packet is held in the buffer at the first cycle that beat is offered.
- R5: m_last is 1 on the final beat of the MAX_PKTS-th packet of a burst, and the count of merged packets then restarts at zero.
- R6: Between packets, s_ready is 0 whenever fewer than MAX_PKT_BEATS buffer slots are free; inside a packet, s_ready is 1 while any slot is free.
- R7: While m_valid is 1 and m_ready is 0, m_valid, m_data, m_keep and m_last hold their values.
- R8: During and right after reset, m_valid is 0 and s_ready is 1.
- R9: No beat of a packet is offered on the output before that packet's final beat has been accepted (store-and-forward).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Input beat valid |
| s_ready | output | 1 | Input beat accepted when high with s_valid |
| s_data | input | DATA_W | Input beat data |
| s_keep | input | DATA_W/8 | Input byte enables |
| s_last | input | 1 | Final beat of input packet |
| s_user | input | 1 | Error mark, sampled with s_last |
| m_valid | output | 1 | Output beat valid |
| m_ready | input | 1 | Downstream ready |
| m_data | output | DATA_W | Output beat data |
| m_keep | output | DATA_W/8 | Output byte enables |
| m_last | output | 1 | End of combined burst |

## Verification
The bench builds the block with 16-bit data, a 16-slot buffer, packets of at most 4 beats and a limit of 3 packets per burst. These small values let the bench fill the buffer completely while the output is stalled, reach the intake gate, and sweep every packet length from 1 to 4 against group sizes of 1 to 5. This covers bursts cut by the packet limit, bursts cut by an empty buffer, and the one-beat packet whose last flag is already shown before later packets arrive. Expected last positions are computed in the bench from the group size and the limit.

// File: rtl/pkt_combiner_pkg.sv
package pkt_combiner_pkg;

  // Intake gate: a new packet needs room for a maximum-length packet,
  // a packet already under way only needs one slot.
  function automatic logic room_for_beat(input int unsigned free_slots,
                                         input int unsigned max_beats,
                                         input logic        mid_packet);
    return mid_packet ? (free_slots != 0) : (free_slots >= max_beats);
  endfunction

  // Boundary rule at a packet's final beat.
  function automatic logic burst_closes(input logic held,
                                        input logic more_waiting,
                                        input logic at_limit);
    return held || !more_waiting || at_limit;
  endfunction

endpackage

// File: rtl/pkt_combiner_buffer.sv
module pkt_combiner_buffer
  import pkt_combiner_pkg::*;
#(
  parameter int DATA_W        = 32,
  parameter int DEPTH         = 64,
  parameter int MAX_PKT_BEATS = 16,
  localparam int KEEP_W = DATA_W / 8,
  localparam int AW     = $clog2(DEPTH),
  localparam int PW     = AW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [KEEP_W-1:0] wr_keep,
  input  logic              wr_last,
  input  logic              wr_err,
  output logic              rd_avail,
  input  logic              rd_take,
  output logic [DATA_W-1:0] rd_data,
  output logic [KEEP_W-1:0] rd_keep,
  output logic              rd_eop,
  output logic              commit_pulse,
  output logic              drop_pulse,
  output logic [PW-1:0]     free_slots,
  output logic              open_pkt
);
  localparam int EW = DATA_W + KEEP_W + 1;

  logic [EW-1:0] store [DEPTH];
  logic [PW-1:0] wr_ptr, cmt_ptr, rd_ptr;
  logic [PW-1:0] used;
  logic          wr_fire;
  logic [EW-1:0] head;

  assign used       = wr_ptr - rd_ptr;
  assign free_slots = PW'(DEPTH) - used;
  assign wr_ready   = room_for_beat(int'(free_slots), MAX_PKT_BEATS, open_pkt);
  assign wr_fire    = wr_valid && wr_ready;

  assign commit_pulse = wr_fire && wr_last && !wr_err;
  assign drop_pulse   = wr_fire && wr_last && wr_err;

  always_ff @(posedge clk) begin
    if (wr_fire) store[wr_ptr[AW-1:0]] <= {wr_last, wr_keep, wr_data};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      cmt_ptr  <= '0;
      rd_ptr   <= '0;
      open_pkt <= 1'b0;
    end else begin
      if (wr_fire) begin
        open_pkt <= !wr_last;
        if (drop_pulse) begin
          wr_ptr <= cmt_ptr;
        end else begin
          wr_ptr <= wr_ptr + 1'b1;
          if (commit_pulse) cmt_ptr <= wr_ptr + 1'b1;
        end
      end
      if (rd_take) rd_ptr <= rd_ptr + 1'b1;
    end
  end

  assign rd_avail = (rd_ptr != cmt_ptr);
  assign head     = store[rd_ptr[AW-1:0]];
  assign rd_data  = head[DATA_W-1:0];
  assign rd_keep  = head[DATA_W +: KEEP_W];
  assign rd_eop   = head[EW-1];

endmodule

// File: rtl/pkt_combiner_ctrl.sv
module pkt_combiner_ctrl
  import pkt_combiner_pkg::*;
#(
  parameter int DEPTH    = 64,
  parameter int MAX_PKTS = 8,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int MW = $clog2(MAX_PKTS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_avail,
  input  logic          rd_eop,
  input  logic          commit_pulse,
  input  logic          out_ready,
  output logic          out_valid,
  output logic          out_last,
  output logic          rd_take,
  output logic [CW-1:0] pkt_held,
  output logic [MW-1:0] merged
);
  logic held_last;
  logic more_waiting;
  logic at_limit;
  logic eop_fire;

  assign out_valid    = rd_avail;
  assign rd_take      = rd_avail && out_ready;
  assign eop_fire     = rd_take && rd_eop;
  assign more_waiting = (pkt_held > CW'(1));
  assign at_limit     = (merged == MW'(MAX_PKTS - 1));
  assign out_last     = rd_avail && rd_eop && burst_closes(held_last, more_waiting, at_limit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pkt_held  <= '0;
      merged    <= '0;
      held_last <= 1'b0;
    end else begin
      pkt_held <= pkt_held + CW'(commit_pulse) - CW'(eop_fire);
      if (eop_fire) merged <= out_last ? '0 : merged + 1'b1;
      if (rd_take)       held_last <= 1'b0;
      else if (out_last) held_last <= 1'b1;
    end
  end

endmodule

// File: rtl/pkt_combiner.sv
module pkt_combiner #(
  parameter int DATA_W        = 32,
  parameter int DEPTH         = 64,
  parameter int MAX_PKT_BEATS = 16,
  parameter int MAX_PKTS      = 8,
  localparam int KEEP_W = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DATA_W-1:0] s_data,
  input  logic [KEEP_W-1:0] s_keep,
  input  logic              s_last,
  input  logic              s_user,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [DATA_W-1:0] m_data,
  output logic [KEEP_W-1:0] m_keep,
  output logic              m_last
);
  localparam int PW = $clog2(DEPTH) + 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int MW = $clog2(MAX_PKTS + 1);

  logic          rd_avail, rd_take, rd_eop;
  logic          commit_pulse, drop_pulse;
  logic [PW-1:0] free_slots;
  logic          open_pkt;
  logic [CW-1:0] pkt_held;
  logic [MW-1:0] merged;

  pkt_combiner_buffer #(
    .DATA_W(DATA_W), .DEPTH(DEPTH), .MAX_PKT_BEATS(MAX_PKT_BEATS)
  ) u_buf (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(s_valid), .wr_ready(s_ready), .wr_data(s_data),
    .wr_keep(s_keep), .wr_last(s_last), .wr_err(s_user),
    .rd_avail(rd_avail), .rd_take(rd_take), .rd_data(m_data),
    .rd_keep(m_keep), .rd_eop(rd_eop),
    .commit_pulse(commit_pulse), .drop_pulse(drop_pulse),
    .free_slots(free_slots), .open_pkt(open_pkt)
  );

  pkt_combiner_ctrl #(
    .DEPTH(DEPTH), .MAX_PKTS(MAX_PKTS)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .rd_avail(rd_avail), .rd_eop(rd_eop), .commit_pulse(commit_pulse),
    .out_ready(m_ready), .out_valid(m_valid), .out_last(m_last),
    .rd_take(rd_take), .pkt_held(pkt_held), .merged(merged)
  );

endmodule

// File: rtl/pkt_combiner_checker.sv
module pkt_combiner_checker #(
  parameter int DATA_W        = 32,
  parameter int DEPTH         = 64,
  parameter int MAX_PKT_BEATS = 16,
  parameter int MAX_PKTS      = 8,
  localparam int KEEP_W = DATA_W / 8,
  localparam int PW     = $clog2(DEPTH) + 1,
  localparam int CW     = $clog2(DEPTH + 1),
  localparam int MW     = $clog2(MAX_PKTS + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              s_ready,
  input logic              m_valid,
  input logic              m_ready,
  input logic [DATA_W-1:0] m_data,
  input logic [KEEP_W-1:0] m_keep,
  input logic              m_last,
  input logic              rd_eop,
  input logic              drop_pulse,
  input logic              commit_pulse,
  input logic [PW-1:0]     free_slots,
  input logic              open_pkt,
  input logic [CW-1:0]     pkt_held,
  input logic [MW-1:0]     merged
);

  assert_hold_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |=> m_valid && $stable(m_data) && $stable(m_keep) && $stable(m_last));

  assert_last_at_eop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && m_last |-> rd_eop);

  assert_limit_close_R5: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && rd_eop && (merged == MW'(MAX_PKTS - 1)) |-> m_last);

  assert_merge_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    merged < MW'(MAX_PKTS));

  assert_alone_close_R4: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && rd_eop && (pkt_held == CW'(1)) |-> m_last);

  assert_intake_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready && !open_pkt |-> free_slots >= PW'(MAX_PKT_BEATS));

  assert_complete_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> pkt_held != '0);

  assert_drop_no_commit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    drop_pulse |=> $stable(pkt_held) || $past(m_valid && m_ready && rd_eop));

  assert_drop_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(drop_pulse && commit_pulse));

endmodule

bind pkt_combiner pkt_combiner_checker #(
  .DATA_W(DATA_W), .DEPTH(DEPTH), .MAX_PKT_BEATS(MAX_PKT_BEATS), .MAX_PKTS(MAX_PKTS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .s_ready(s_ready), .m_valid(m_valid),
  .m_ready(m_ready), .m_data(m_data), .m_keep(m_keep), .m_last(m_last),
  .rd_eop(rd_eop), .drop_pulse(drop_pulse), .commit_pulse(commit_pulse),
  .free_slots(free_slots), .open_pkt(open_pkt), .pkt_held(pkt_held),
  .merged(merged)
);

// File: tb/pkt_combiner_test.sv
`timescale 1ns/1ps
module pkt_combiner_test;
  localparam int DW  = 16;
  localparam int KW  = DW / 8;
  localparam int DEP = 16;
  localparam int MPB = 4;
  localparam int MPK = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic s_valid = 1'b0, s_last = 1'b0, s_user = 1'b0;
  logic [DW-1:0] s_data = '0;
  logic [KW-1:0] s_keep = '0;
  logic s_ready, m_valid, m_last;
  logic m_ready = 1'b1;
  logic [DW-1:0] m_data;
  logic [KW-1:0] m_keep;

  always #2 clk = ~clk;

  pkt_combiner #(.DATA_W(DW), .DEPTH(DEP), .MAX_PKT_BEATS(MPB), .MAX_PKTS(MPK)) uut (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .s_keep(s_keep), .s_last(s_last), .s_user(s_user),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_keep(m_keep),
    .m_last(m_last));

  int checks = 0, errors = 0, cyc = 0;
  logic [DW-1:0] exp_data [0:1023];
  logic [KW-1:0] exp_keep [0:1023];
  logic          exp_last [0:1023];
  int            pkt_end  [0:511];
  logic [DW-1:0] got_data [0:1023];
  logic [KW-1:0] got_keep [0:1023];
  logic          got_last [0:1023];
  int n_exp = 0, n_got = 0, n_pk = 0, cmp_at = 0;

  always @(negedge clk) begin
    cyc++;
    if (rst_n && m_valid && m_ready && n_got < 1024) begin
      got_data[n_got] = m_data;
      got_keep[n_got] = m_keep;
      got_last[n_got] = m_last;
      n_got++;
    end
    if (cyc == 150000) begin
      checks++; errors++;
      $display("FAIL R1 watchdog expired: actual cycles %0d expected fewer", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input logic ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, expv);
    end
  endtask

  function automatic logic [DW-1:0] pat_data(input int seed, input int b);
    return DW'((seed * 256 + b * 17 + 5) & 16'hffff);
  endfunction

  function automatic logic [KW-1:0] pat_keep(input int seed, input int b);
    int m = (seed + b) % 3;
    return (m == 0) ? 2'b01 : ((m == 1) ? 2'b10 : 2'b11);
  endfunction

  task automatic put_beat(input logic [DW-1:0] d, input logic [KW-1:0] k,
                          input logic l, input logic e);
    logic taken = 1'b0;
    s_valid = 1'b1; s_data = d; s_keep = k; s_last = l; s_user = e;
    while (!taken) begin
      @(negedge clk);
      taken = s_ready;
      @(posedge clk);
      #1;
    end
    s_valid = 1'b0; s_last = 1'b0; s_user = 1'b0;
  endtask

  task automatic send_pkt(input int len, input int seed, input logic err);
    for (int b = 0; b < len; b++) begin
      put_beat(pat_data(seed, b), pat_keep(seed, b), b == len - 1, err && (b == len - 1));
      if (!err) begin
        exp_data[n_exp] = pat_data(seed, b);
        exp_keep[n_exp] = pat_keep(seed, b);
        exp_last[n_exp] = 1'b0;
        n_exp++;
      end
    end
    if (!err) begin
      pkt_end[n_pk] = n_exp - 1;
      n_pk++;
    end
  endtask

  // Expected burst ends for a group of n packets; the first `base` packets
  // close on their own (their last was already offered before the rest arrived).
  task automatic mark_group(input int first, input int n, input int base);
    for (int i = 0; i < n; i++)
      if (i < base || ((i - base + 1) % MPK == 0) || i == n - 1)
        exp_last[pkt_end[first + i]] = 1'b1;
  endtask

  task automatic drain_compare(input string tag);
    int w = 0;
    while ((n_got < n_exp || m_valid) && w < 400) begin
      @(posedge clk); #1; w++;
    end
    repeat (3) @(posedge clk);
    #1;
    check(n_got == n_exp, {"R1 beat count ", tag}, n_got, n_exp);
    for (int i = cmp_at; i < n_exp && i < n_got; i++) begin
      check(got_data[i] == exp_data[i] && got_keep[i] == exp_keep[i],
            {"R1 data/keep ", tag}, {got_keep[i], got_data[i]}, {exp_keep[i], exp_data[i]});
      check(got_last[i] == exp_last[i], {"R3 R4 R5 last flag ", tag},
            int'(got_last[i]), int'(exp_last[i]));
    end
    cmp_at = n_exp;
  endtask

  initial begin
    logic [DW-1:0] snap;
    int first, base;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!m_valid, "R8 m_valid in reset", int'(m_valid), 0);
    check(s_ready, "R8 s_ready in reset", int'(s_ready), 1);
    @(posedge clk); #1; rst_n = 1'b1;
    @(negedge clk);
    check(!m_valid && s_ready, "R8 idle after reset", {m_valid, s_ready}, 1);
    @(posedge clk); #1;

    // Isolated packets: each closes its own burst (R4).
    for (int len = 1; len <= MPB; len++) begin
      first = n_pk;
      send_pkt(len, len, 1'b0);
      mark_group(first, 1, 0);
      drain_compare("isolated");
    end

    // Errored packet alone produces nothing (R2), then a good one follows.
    send_pkt(3, 40, 1'b1);
    repeat (10) @(posedge clk);
    #1;
    check(n_got == n_exp, "R2 errored packet emitted beats", n_got, n_exp);
    first = n_pk;
    send_pkt(2, 41, 1'b0);
    mark_group(first, 1, 0);
    drain_compare("after drop R2");

    // Store-and-forward: partial packet stays hidden (R9).
    first = n_pk;
    put_beat(pat_data(50, 0), pat_keep(50, 0), 1'b0, 1'b0);
    put_beat(pat_data(50, 1), pat_keep(50, 1), 1'b0, 1'b0);
    repeat (5) @(posedge clk);
    @(negedge clk);
    check(!m_valid, "R9 partial packet offered", int'(m_valid), 0);
    @(posedge clk); #1;
    put_beat(pat_data(50, 2), pat_keep(50, 2), 1'b1, 1'b0);
    for (int b = 0; b < 3; b++) begin
      exp_data[n_exp] = pat_data(50, b); exp_keep[n_exp] = pat_keep(50, b);
      exp_last[n_exp] = 1'b0; n_exp++;
    end
    pkt_end[n_pk] = n_exp - 1; n_pk++;
    mark_group(first, 1, 0);
    drain_compare("R9");

    // Stalled fill with a dropped packet in the middle, intake gate, hold.
    m_ready = 1'b0;
    first = n_pk;
    send_pkt(2, 60, 1'b0);
    send_pkt(3, 61, 1'b0);
    send_pkt(4, 62, 1'b1);
    send_pkt(1, 63, 1'b0);
    send_pkt(4, 64, 1'b0);
    send_pkt(2, 65, 1'b0);
    send_pkt(3, 66, 1'b0);
    @(negedge clk);
    check(!s_ready, "R6 intake gate with 1 free slot", int'(s_ready), 0);
    snap = m_data;
    check(m_valid && !m_last, "R7 head offered under stall", {m_valid, m_last}, 2);
    repeat (4) @(negedge clk);
    check(m_valid && m_data == snap && !m_last, "R7 head stable under stall",
          int'(m_data), int'(snap));
    @(posedge clk); #1;
    mark_group(first, 6, 0);
    m_ready = 1'b1;
    drain_compare("stalled fill R2 R5");

    // Sweep of group size against packet length with output stalled.
    for (int len = 1; len <= MPB; len++) begin
      for (int k = 1; k <= 5; k++) begin
        if ((k - 1) * len <= DEP - MPB) begin
          m_ready = 1'b0;
          first = n_pk;
          for (int p = 0; p < k; p++) send_pkt(len, 100 + len * 8 + p, 1'b0);
          repeat (2) @(posedge clk);
          #1;
          base = (len == 1) ? 1 : 0;
          mark_group(first, k, base);
          m_ready = 1'b1;
          drain_compare("sweep R5");
        end
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule